// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands of `W` bits (default 4) and returns a product of `2W` bits. Its structure is a classic array multiplier: an AND array forms the partial products, and `W-1` ripple-carry adder rows fold them together, one row per bit of the second operand above bit 0. Between every pair of rows sits a register bank, so one operand pair enters on every rising clock edge and its product leaves a fixed number of clocks later.

Both operands are captured in input registers first. The product bits that settle in early rows travel down the pipeline alongside the running sum. All `2W` output bits therefore always belong to the same operand pair. There is no enable, no stall and no reset. The stream moves forward on every clock, and the output is meaningful once the pipeline has filled.

The block has a fixed-latency data path with no back-pressure. A valid/ready handshake would add stall logic that the block does not need, so the ports are plain data. The consumer takes each product exactly `W` clocks after it presented the operands.

Top module: `mulpipe_top`

## Requirements
- R1: For every pair of unsigned operands, `p` equals `x * y` as a `2W`-bit unsigned value. With the default `W=4`, all 256 pairs give the exact product.
- R2: Operands present at rising edge n appear as their product on `p` right after rising edge n+W-1, where W is 4 by default. That is `W` register stages, counting the input capture. Until then, `p` still shows the product of earlier pairs.
- R3: A new operand pair is accepted on every rising edge. Back-to-back pairs that all differ each produce their own correct product on consecutive clocks.
- R4: All bits of `p` in one cycle belong to a single operand pair. Alternating extreme pairs such as (15,15) and (0,0) never yield a mix of low bits from one pair and high bits from another.
- R5: If either operand is zero, the product is zero.
- R6: Bit 0 of `p` equals bit 0 of `x` AND bit 0 of `y` for the same pair.
- R7: If one operand is 1, the product equals the other operand, zero-extended.
- R8: The largest operands give the largest product: 15*15 = 225 (0xE1) for `W=4`, with no lost carry out of the top row.
- R9: The operands are sampled only at the rising edge. Changes to `x` and `y` between edges that are undone before the next edge have no effect on any product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every stage advances on the rising edge |
| x | input | W | Multiplicand, unsigned |
| y | input | W | Multiplier, unsigned |
| p | output | 2W | Registered product of the pair presented W clocks earlier |

## Verification
A pair driven before rising edge n is due on `p` after edge n+W-1. With the default width that is the fourth rising edge, counting the capture edge. The bench records that due edge with every expected product it queues. The monitor compares only in the half cycle after the due edge, away from any active edge, so both a latency that is too short and one that is too long show up as mismatches. Mid-cycle glitches on the operands are placed after an edge and undone before the next one, and the product due for that cycle must be unchanged.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;

  // Result of a one-bit full adder.
  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic a, input logic b, input logic ci);
    fa_out_t r;
    r.sum   = a ^ b ^ ci;
    r.carry = (a & b) | (a & ci) | (b & ci);
    return r;
  endfunction

endpackage

// File: rtl/mulpipe_ripple_add.sv
module mulpipe_ripple_add
  import mulpipe_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    fa_out_t fa;
    assign fa          = full_add(a[i], b[i], chain[i]);
    assign sum[i]      = fa.sum;
    assign chain[i+1]  = fa.carry;
  end

  assign cout = chain[W];

endmodule

// File: rtl/mulpipe_row.sv
// One adder row of the array plus its register bank.
module mulpipe_row #(
  parameter int W = 4,
  parameter int K = 1   // multiplier bit handled by this row
) (
  input  logic         clk,
  input  logic [W-1:0] x_in,
  input  logic         y_bit,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] lo_q
);

  logic [W-1:0] pp;
  logic [W-1:0] sum;
  logic         cout;
  logic [W-1:0] lo_nxt;

  assign pp = x_in & {W{y_bit}};

  mulpipe_ripple_add #(.W(W)) u_add (
    .a    (pp),
    .b    (acc_in),
    .cin  (1'b0),
    .sum  (sum),
    .cout (cout)
  );

  // The row's sum LSB is finished product bit K.
  assign lo_nxt = lo_in | (W'(sum[0]) << K);

  always_ff @(posedge clk) begin
    acc_q <= {cout, sum[W-1:1]};
    lo_q  <= lo_nxt;
  end

endmodule

// File: rtl/mulpipe_top.sv
module mulpipe_top #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);

  localparam int ROWS = W - 1;

  logic [W-1:0] xr, yr;

  // Operand copies travelling with each stage; ys[k][0] is the
  // multiplier bit used by row k+1.
  logic [W-1:0] xs [0:ROWS-1];
  logic [W-1:0] ys [0:ROWS-1];
  logic [W-1:0] acc [0:ROWS];
  logic [W-1:0] lo  [0:ROWS];

  always_ff @(posedge clk) begin
    xr <= x;
    yr <= y;
  end

  // Stage 0: row of y[0] products and product bit 0.
  assign xs[0]  = xr;
  assign ys[0]  = {1'b0, yr[W-1:1]};
  assign acc[0] = {1'b0, xr[W-1:1] & {(W-1){yr[0]}}};
  assign lo[0]  = {{(W-1){1'b0}}, xr[0] & yr[0]};

  for (genvar k = 1; k <= ROWS; k++) begin : g_row
    mulpipe_row #(.W(W), .K(k)) u_row (
      .clk    (clk),
      .x_in   (xs[k-1]),
      .y_bit  (ys[k-1][0]),
      .acc_in (acc[k-1]),
      .lo_in  (lo[k-1]),
      .acc_q  (acc[k]),
      .lo_q   (lo[k])
    );

    if (k < ROWS) begin : g_fwd
      always_ff @(posedge clk) begin
        xs[k] <= xs[k-1];
        ys[k] <= ys[k-1] >> 1;
      end
    end
  end

  assign p = {acc[ROWS], lo[ROWS]};

endmodule

// File: rtl/mulpipe_checker.sv
module mulpipe_checker #(
  parameter int W = 4
) (
  input logic           clk,
  input logic [W-1:0]   x,
  input logic [W-1:0]   y,
  input logic [2*W-1:0] p
);

  localparam int CW = $clog2(W + 1) + 1;

  logic [W-1:0] hx [0:W-1];
  logic [W-1:0] hy [0:W-1];
  logic [CW-1:0] fill = '0;
  logic warm;

  always_ff @(posedge clk) begin
    hx[0] <= x;
    hy[0] <= y;
    for (int i = 1; i < W; i++) begin
      hx[i] <= hx[i-1];
      hy[i] <= hy[i-1];
    end
    if (fill < CW'(W)) fill <= fill + 1'b1;
  end

  assign warm = (fill == CW'(W));

  // R1 R2
  product_match_chk: assert property (@(posedge clk) disable iff (!warm)
    p == (2*W)'(hx[W-1]) * (2*W)'(hy[W-1]));

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (!warm)
    (hx[W-1] == '0 || hy[W-1] == '0) |-> p == '0);

  // R7
  unit_operand_chk: assert property (@(posedge clk) disable iff (!warm)
    (hy[W-1] == W'(1)) |-> p == {{W{1'b0}}, hx[W-1]});

  // R6
  low_bit_chk: assert property (@(posedge clk) disable iff (!warm)
    p[0] == (hx[W-1][0] & hy[W-1][0]));

endmodule

bind mulpipe_top mulpipe_checker #(.W(W)) u_chk (
  .clk (clk),
  .x   (x),
  .y   (y),
  .p   (p)
);

// File: tb/mulpipe_top_test.sv
module mulpipe_top_test;

  localparam int PERIOD = 10;
  localparam int W      = 4;

  logic           clk = 1'b0;
  logic [W-1:0]   x = '0;
  logic [W-1:0]   y = '0;
  logic [2*W-1:0] p;

  int checks = 0;
  int errors = 0;
  int ecnt   = 0;
  bit done   = 1'b0;

  int             q_due [$];
  logic [2*W-1:0] q_exp [$];
  string          q_tag [$];

  mulpipe_top #(.W(W)) uut (.clk(clk), .x(x), .y(y), .p(p));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  // Driver: present a pair at a falling edge, queue its product due
  // W-1 edges after the capture edge (ecnt+1).
  task automatic drive(input int a, input int b, input string tag);
    @(negedge clk);
    x = W'(a);
    y = W'(b);
    q_due.push_back(ecnt + W);
    q_exp.push_back((2*W)'(a * b));
    q_tag.push_back(tag);
  endtask

  // Same, then scramble the operands mid-cycle (R9).
  task automatic drive_glitch(input int a, input int b);
    drive(a, b, "R9");
    @(posedge clk);
    #(PERIOD/4);
    x = ~x;
    y = ~y;
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == ecnt) begin
      logic [2*W-1:0] e;
      string t;
      void'(q_due.pop_front());
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (p !== e) begin
        errors++;
        $display("FAIL %s: p=%0d expected %0d", t, p, e);
      end
      if (t == "R6") begin
        checks++;
        if (p[0] !== e[0]) begin
          errors++;
          $display("FAIL R6: p[0]=%0b expected %0b", p[0], e[0]);
        end
      end
    end
  end

  initial begin
    // R1 R3: all pairs, back to back
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        drive(a, b, "R1");
    // R5: zero operand
    drive(0, 13, "R5"); drive(11, 0, "R5"); drive(0, 0, "R5");
    // R7: unit operand
    drive(1, 9, "R7"); drive(14, 1, "R7"); drive(1, 1, "R7");
    // R8: extremes
    drive(15, 15, "R8"); drive(15, 1, "R8"); drive(1, 15, "R8");
    // R4: alternating extremes, no mixed bits
    for (int i = 0; i < 6; i++) begin
      drive(15, 15, "R4"); drive(0, 0, "R4");
      drive(10, 5, "R4");  drive(5, 10, "R4");
    end
    // R2: hold one pair, then switch; the old product must persist
    // until exactly the due edge of the new one
    for (int i = 0; i < 6; i++) drive(3, 3, "R2");
    drive(7, 9, "R2"); drive(7, 9, "R2");
    // R6: low bit for odd/even mixes
    drive(3, 5, "R6"); drive(6, 7, "R6"); drive(9, 2, "R6"); drive(13, 11, "R6");
    // R9: mid-cycle glitches
    drive_glitch(12, 6); drive_glitch(5, 3); drive_glitch(0, 15);
    drive(2, 2, "R9");
    while (q_due.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, pending=%0d expected 0", q_due.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule